// File: doc/BRIEF.md
# Data-Capture Wakeup Issue Queue

This block is the waiting room between dispatch and execution in an out-of-order core. Each slot keeps one instruction: an opcode, a destination tag and two source operands. Each source operand has a tag, a ready flag and a stored value. Dispatch writes a slot at an index chosen outside the block. It supplies any operand values that already exist. For a missing operand it supplies the producer's tag and a small wakeup delay.

Every cycle, each waiting source compares its tag with all result broadcast buses. On a match the source stores the broadcast value. It becomes ready either at once or after the programmed number of extra cycles. The delayed case lets a consumer of a fixed multi-cycle producer wait out that producer's latency.

A slot bids for issue once both sources are ready and it has not issued yet. An external select block answers with a one-hot grant. The granted slot's opcode, destination and stored values then appear on a registered issue port. The slot stays occupied, but it stops bidding until dispatch logic frees it with a per-slot release pulse.

Top module: `wkq_queue`

## Requirements
- R1: After reset every bit of `bid` is 0 and `iss_valid` is 0.
- R2: A slot written with both sources marked ready has its `bid` bit set from the clock edge that writes it.
- R3: A waiting source whose delay is 0 matches a bus `b` when `bc_valid[b]` is 1 and bits `[b*TAG_W +: TAG_W]` of `bc_tag` equal its tag. At that edge it becomes ready and stores bits `[b*VAL_W +: VAL_W]` of `bc_val`. If several buses match, the lowest bus index supplies the value.
- R4: A waiting source with delay d (1 to 3) stores the value at the matching edge E. It becomes ready at edge E+d, and broadcasts in between have no effect on it.
- R5: When a write marks a source not ready and a bus carries that source's tag in the same cycle, the broadcast is taken exactly as a later match would be, with the written delay.
- R6: A grant to a bidding slot at edge E drives `iss_valid`=1 after E, together with that slot's opcode, destination tag, left value and right value.
- R7: A slot that has been granted clears its `bid` bit from the granting edge onward, until the slot is written again.
- R8: A release pulse on `dealloc[i]` clears `bid[i]` from that edge onward. A free slot takes no broadcast. A write to the same slot in the same cycle wins over the release.
- R9: A grant to a slot that is not bidding has no effect: `iss_valid` is 0 after that edge and the slot's state does not change.
- R10: A source that is already ready ignores later broadcasts of its tag. The value it issues is the one stored first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_en | input | 1 | Write a slot this cycle |
| alloc_idx | input | IDX_W | Slot written |
| alloc_opc | input | OPC_W | Opcode for the slot |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_l_tag | input | TAG_W | Left source tag |
| alloc_l_rdy | input | 1 | Left value already present |
| alloc_l_val | input | VAL_W | Left value when present |
| alloc_l_dly | input | DLY_W | Extra wakeup cycles for left source |
| alloc_r_tag | input | TAG_W | Right source tag |
| alloc_r_rdy | input | 1 | Right value already present |
| alloc_r_val | input | VAL_W | Right value when present |
| alloc_r_dly | input | DLY_W | Extra wakeup cycles for right source |
| bc_valid | input | BUSES | Broadcast bus valid, one bit per bus |
| bc_tag | input | BUSES*TAG_W | Broadcast tags, bus b at [b*TAG_W +: TAG_W] |
| bc_val | input | BUSES*VAL_W | Broadcast values, bus b at [b*VAL_W +: VAL_W] |
| dealloc | input | ENTRIES | Per-slot release pulse |
| grant | input | ENTRIES | One-hot grant from select |
| bid | output | ENTRIES | Per-slot issue request |
| iss_valid | output | 1 | Issue port carries an instruction |
| iss_opc | output | OPC_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_l_val | output | VAL_W | Issued left value |
| iss_r_val | output | VAL_W | Issued right value |

## Verification
The bench targets a broadcast that coincides with the slot write. A design that only looks at stored tags would miss it, and the slot would wait forever. It checks that the delayed wakeup fires exactly d edges after the match; an off-by-one counter moves the first bid a cycle early or late. It sends two buses with the same tag and different values; wrong priority shows up as the other bus's value on the issue port. Late re-broadcasts to an already-ready source, grants to idle slots and a write colliding with a release are also driven. Each of these would corrupt an issued value, produce a spurious issue or drop a live slot.

// File: rtl/wkq_pkg.sv
package wkq_pkg;
   typedef enum logic [1:0] {
      SRC_WAIT  = 2'd0,
      SRC_COUNT = 2'd1,
      SRC_READY = 2'd2
   } src_state_e;
endpackage

// File: rtl/wkq_tagmatch.sv
module wkq_tagmatch #(
   parameter int TAG_W = 6,
   parameter int VAL_W = 32,
   parameter int BUSES = 2
) (
   input  logic [TAG_W-1:0]       probe_tag,
   input  logic [BUSES-1:0]       bc_valid,
   input  logic [BUSES*TAG_W-1:0] bc_tag,
   input  logic [BUSES*VAL_W-1:0] bc_val,
   output logic                   hit,
   output logic [VAL_W-1:0]       hit_val
);
   logic [BUSES-1:0] eq;

   genvar b;
   generate
      for (b = 0; b < BUSES; b++) begin : g_cmp
         assign eq[b] = bc_valid[b] && (bc_tag[b*TAG_W +: TAG_W] == probe_tag);
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_val = '0;
      for (int k = BUSES - 1; k >= 0; k--) begin
         if (eq[k]) begin
            hit     = 1'b1;
            hit_val = bc_val[k*VAL_W +: VAL_W];
         end
      end
   end
endmodule

// File: rtl/wkq_src.sv
module wkq_src
   import wkq_pkg::*;
#(
   parameter int TAG_W     = 6,
   parameter int VAL_W     = 32,
   parameter int DLY_W     = 2,
   parameter int BUSES     = 2,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   live,
   input  logic                   alloc_we,
   input  logic [TAG_W-1:0]       a_tag,
   input  logic                   a_rdy,
   input  logic [VAL_W-1:0]       a_val,
   input  logic [DLY_W-1:0]       a_dly,
   input  logic [BUSES-1:0]       bc_valid,
   input  logic [BUSES*TAG_W-1:0] bc_tag,
   input  logic [BUSES*VAL_W-1:0] bc_val,
   output logic                   rdy,
   output logic [VAL_W-1:0]       val
);
   src_state_e       st_q, st_d;
   logic [TAG_W-1:0] tag_q, tag_d;
   logic [DLY_W-1:0] dly_q, dly_d, cnt_q, cnt_d, eff_dly;
   logic [VAL_W-1:0] val_q, val_d, hit_val;
   logic [TAG_W-1:0] cmp_tag;
   logic             hit;

   assign cmp_tag = alloc_we ? a_tag : tag_q;

   wkq_tagmatch #(.TAG_W(TAG_W), .VAL_W(VAL_W), .BUSES(BUSES)) u_match (
      .probe_tag (cmp_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_val    (bc_val),
      .hit       (hit),
      .hit_val   (hit_val)
   );

   generate
      if (USE_DELAY) begin : g_dly
         assign eff_dly = alloc_we ? a_dly : dly_q;
      end else begin : g_nodly
         assign eff_dly = '0;
      end
   endgenerate

   always_comb begin
      st_d  = st_q;
      tag_d = tag_q;
      dly_d = dly_q;
      cnt_d = cnt_q;
      val_d = val_q;
      if (alloc_we) begin
         tag_d = a_tag;
         dly_d = a_dly;
         st_d  = SRC_WAIT;
      end
      if (alloc_we && a_rdy) begin
         st_d  = SRC_READY;
         val_d = a_val;
      end else if ((alloc_we || (live && st_q == SRC_WAIT)) && hit) begin
         val_d = hit_val;
         if (eff_dly == '0) begin
            st_d = SRC_READY;
         end else begin
            st_d  = SRC_COUNT;
            cnt_d = eff_dly;
         end
      end else if (!alloc_we && live && st_q == SRC_COUNT) begin
         cnt_d = cnt_q - DLY_W'(1);
         if (cnt_q == DLY_W'(1)) st_d = SRC_READY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SRC_WAIT;
         tag_q <= '0;
         dly_q <= '0;
         cnt_q <= '0;
         val_q <= '0;
      end else begin
         st_q  <= st_d;
         tag_q <= tag_d;
         dly_q <= dly_d;
         cnt_q <= cnt_d;
         val_q <= val_d;
      end
   end

   assign rdy = (st_q == SRC_READY);
   assign val = val_q;
endmodule

// File: rtl/wkq_entry.sv
module wkq_entry #(
   parameter int TAG_W     = 6,
   parameter int VAL_W     = 32,
   parameter int DLY_W     = 2,
   parameter int OPC_W     = 8,
   parameter int BUSES     = 2,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_we,
   input  logic [OPC_W-1:0]       a_opc,
   input  logic [TAG_W-1:0]       a_dst,
   input  logic [TAG_W-1:0]       a_l_tag,
   input  logic                   a_l_rdy,
   input  logic [VAL_W-1:0]       a_l_val,
   input  logic [DLY_W-1:0]       a_l_dly,
   input  logic [TAG_W-1:0]       a_r_tag,
   input  logic                   a_r_rdy,
   input  logic [VAL_W-1:0]       a_r_val,
   input  logic [DLY_W-1:0]       a_r_dly,
   input  logic [BUSES-1:0]       bc_valid,
   input  logic [BUSES*TAG_W-1:0] bc_tag,
   input  logic [BUSES*VAL_W-1:0] bc_val,
   input  logic                   release_i,
   input  logic                   grant_i,
   output logic                   bid,
   output logic                   l_rdy,
   output logic                   r_rdy,
   output logic [OPC_W-1:0]       opc,
   output logic [TAG_W-1:0]       dst,
   output logic [VAL_W-1:0]       l_val,
   output logic [VAL_W-1:0]       r_val
);
   logic occ_q, issued_q;
   logic [OPC_W-1:0] opc_q;
   logic [TAG_W-1:0] dst_q;

   wkq_src #(.TAG_W(TAG_W), .VAL_W(VAL_W), .DLY_W(DLY_W), .BUSES(BUSES),
             .USE_DELAY(USE_DELAY)) u_left (
      .clk(clk), .rst_n(rst_n), .live(occ_q), .alloc_we(alloc_we),
      .a_tag(a_l_tag), .a_rdy(a_l_rdy), .a_val(a_l_val), .a_dly(a_l_dly),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .rdy(l_rdy), .val(l_val)
   );

   wkq_src #(.TAG_W(TAG_W), .VAL_W(VAL_W), .DLY_W(DLY_W), .BUSES(BUSES),
             .USE_DELAY(USE_DELAY)) u_right (
      .clk(clk), .rst_n(rst_n), .live(occ_q), .alloc_we(alloc_we),
      .a_tag(a_r_tag), .a_rdy(a_r_rdy), .a_val(a_r_val), .a_dly(a_r_dly),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .rdy(r_rdy), .val(r_val)
   );

   assign bid = occ_q && !issued_q && l_rdy && r_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q    <= 1'b0;
         issued_q <= 1'b0;
         opc_q    <= '0;
         dst_q    <= '0;
      end else if (alloc_we) begin
         occ_q    <= 1'b1;
         issued_q <= 1'b0;
         opc_q    <= a_opc;
         dst_q    <= a_dst;
      end else begin
         if (release_i) occ_q <= 1'b0;
         if (grant_i && bid) issued_q <= 1'b1;
      end
   end

   assign opc = opc_q;
   assign dst = dst_q;
endmodule

// File: rtl/wkq_queue.sv
module wkq_queue #(
   parameter int ENTRIES   = 8,
   parameter int BUSES     = 2,
   parameter int TAG_W     = 6,
   parameter int VAL_W     = 32,
   parameter int OPC_W     = 8,
   parameter int DLY_W     = 2,
   parameter bit USE_DELAY = 1'b1,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_en,
   input  logic [IDX_W-1:0]       alloc_idx,
   input  logic [OPC_W-1:0]       alloc_opc,
   input  logic [TAG_W-1:0]       alloc_dst,
   input  logic [TAG_W-1:0]       alloc_l_tag,
   input  logic                   alloc_l_rdy,
   input  logic [VAL_W-1:0]       alloc_l_val,
   input  logic [DLY_W-1:0]       alloc_l_dly,
   input  logic [TAG_W-1:0]       alloc_r_tag,
   input  logic                   alloc_r_rdy,
   input  logic [VAL_W-1:0]       alloc_r_val,
   input  logic [DLY_W-1:0]       alloc_r_dly,
   input  logic [BUSES-1:0]       bc_valid,
   input  logic [BUSES*TAG_W-1:0] bc_tag,
   input  logic [BUSES*VAL_W-1:0] bc_val,
   input  logic [ENTRIES-1:0]     dealloc,
   input  logic [ENTRIES-1:0]     grant,
   output logic [ENTRIES-1:0]     bid,
   output logic                   iss_valid,
   output logic [OPC_W-1:0]       iss_opc,
   output logic [TAG_W-1:0]       iss_dst,
   output logic [VAL_W-1:0]       iss_l_val,
   output logic [VAL_W-1:0]       iss_r_val
);
   generate
      if (ENTRIES < 2)  begin : g_bad_entries $error("ENTRIES must be at least 2"); end
      if (BUSES < 1)    begin : g_bad_buses   $error("BUSES must be at least 1"); end
      if (TAG_W < 1)    begin : g_bad_tag     $error("TAG_W must be positive"); end
      if (VAL_W < 1)    begin : g_bad_val     $error("VAL_W must be positive"); end
      if (DLY_W < 1)    begin : g_bad_dly     $error("DLY_W must be positive"); end
   endgenerate

   logic [ENTRIES-1:0] sel, l_rdy, r_rdy;
   logic [OPC_W-1:0]   e_opc [ENTRIES];
   logic [TAG_W-1:0]   e_dst [ENTRIES];
   logic [VAL_W-1:0]   e_lv  [ENTRIES];
   logic [VAL_W-1:0]   e_rv  [ENTRIES];

   genvar i;
   generate
      for (i = 0; i < ENTRIES; i++) begin : g_ent
         logic we;
         assign we = alloc_en && (alloc_idx == IDX_W'(i));
         wkq_entry #(.TAG_W(TAG_W), .VAL_W(VAL_W), .DLY_W(DLY_W), .OPC_W(OPC_W),
                     .BUSES(BUSES), .USE_DELAY(USE_DELAY)) u_ent (
            .clk(clk), .rst_n(rst_n), .alloc_we(we),
            .a_opc(alloc_opc), .a_dst(alloc_dst),
            .a_l_tag(alloc_l_tag), .a_l_rdy(alloc_l_rdy), .a_l_val(alloc_l_val), .a_l_dly(alloc_l_dly),
            .a_r_tag(alloc_r_tag), .a_r_rdy(alloc_r_rdy), .a_r_val(alloc_r_val), .a_r_dly(alloc_r_dly),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
            .release_i(dealloc[i]), .grant_i(grant[i]),
            .bid(bid[i]), .l_rdy(l_rdy[i]), .r_rdy(r_rdy[i]),
            .opc(e_opc[i]), .dst(e_dst[i]), .l_val(e_lv[i]), .r_val(e_rv[i])
         );
      end
   endgenerate

   assign sel = grant & bid;

   logic [OPC_W-1:0] mux_opc;
   logic [TAG_W-1:0] mux_dst;
   logic [VAL_W-1:0] mux_lv, mux_rv;

   always_comb begin
      mux_opc = '0;
      mux_dst = '0;
      mux_lv  = '0;
      mux_rv  = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         if (sel[k]) begin
            mux_opc = mux_opc | e_opc[k];
            mux_dst = mux_dst | e_dst[k];
            mux_lv  = mux_lv  | e_lv[k];
            mux_rv  = mux_rv  | e_rv[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_valid <= 1'b0;
         iss_opc   <= '0;
         iss_dst   <= '0;
         iss_l_val <= '0;
         iss_r_val <= '0;
      end else begin
         iss_valid <= |sel;
         if (|sel) begin
            iss_opc   <= mux_opc;
            iss_dst   <= mux_dst;
            iss_l_val <= mux_lv;
            iss_r_val <= mux_rv;
         end
      end
   end
endmodule

// File: rtl/wkq_checker.sv
module wkq_checker #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               alloc_en,
   input logic [IDX_W-1:0]   alloc_idx,
   input logic [ENTRIES-1:0] grant,
   input logic [ENTRIES-1:0] dealloc,
   input logic [ENTRIES-1:0] bid,
   input logic [ENTRIES-1:0] l_rdy,
   input logic [ENTRIES-1:0] r_rdy,
   input logic               iss_valid
);
   AST_ISSUE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & bid)) |=> iss_valid); // R6
   AST_IDLE_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(grant & bid)) |=> !iss_valid); // R9
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R6

   genvar i;
   generate
      for (i = 0; i < ENTRIES; i++) begin : g_chk
         logic wr;
         assign wr = alloc_en && (alloc_idx == IDX_W'(i));
         AST_NO_REBID: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && bid[i] && !wr) |=> !bid[i]); // R7
         AST_FREED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (dealloc[i] && !wr) |=> !bid[i]); // R8
         AST_LEFT_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (l_rdy[i] && !wr) |=> l_rdy[i]); // R10
         AST_RIGHT_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (r_rdy[i] && !wr) |=> r_rdy[i]); // R10
      end
   endgenerate
endmodule

bind wkq_queue wkq_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_wkq_chk (
   .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
   .grant(grant), .dealloc(dealloc), .bid(bid), .l_rdy(l_rdy), .r_rdy(r_rdy),
   .iss_valid(iss_valid)
);

// File: tb/wkq_queue_test.sv
module wkq_queue_test;
   localparam int N = 8, B = 2, TW = 6, VW = 32, OW = 8, DW = 2, IW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          alloc_en;
   logic [IW-1:0] alloc_idx;
   logic [OW-1:0] alloc_opc;
   logic [TW-1:0] alloc_dst;
   logic [TW-1:0] a_tag [2];
   logic          a_rdy [2];
   logic [VW-1:0] a_val [2];
   logic [DW-1:0] a_dly [2];
   logic [B-1:0]  bc_valid;
   logic [TW-1:0] b_tag [B];
   logic [VW-1:0] b_val [B];
   logic [N-1:0]  dealloc, grant, bid;
   logic          iss_valid;
   logic [OW-1:0] iss_opc;
   logic [TW-1:0] iss_dst;
   logic [VW-1:0] iss_l_val, iss_r_val;

   wkq_queue uut (
      .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
      .alloc_opc(alloc_opc), .alloc_dst(alloc_dst),
      .alloc_l_tag(a_tag[0]), .alloc_l_rdy(a_rdy[0]), .alloc_l_val(a_val[0]), .alloc_l_dly(a_dly[0]),
      .alloc_r_tag(a_tag[1]), .alloc_r_rdy(a_rdy[1]), .alloc_r_val(a_val[1]), .alloc_r_dly(a_dly[1]),
      .bc_valid(bc_valid), .bc_tag({b_tag[1], b_tag[0]}), .bc_val({b_val[1], b_val[0]}),
      .dealloc(dealloc), .grant(grant), .bid(bid), .iss_valid(iss_valid),
      .iss_opc(iss_opc), .iss_dst(iss_dst), .iss_l_val(iss_l_val), .iss_r_val(iss_r_val)
   );

   int checks = 0, failures = 0, cycles = 0;
   string cur_req = "R1";

   // reference state
   bit            m_v [N], m_iss [N];
   bit [OW-1:0]   m_opc [N];
   bit [TW-1:0]   m_dst [N];
   bit            m_rdy [N][2], m_pend [N][2];
   bit [TW-1:0]   m_tag [N][2];
   bit [DW-1:0]   m_dly [N][2], m_cnt [N][2];
   bit [VW-1:0]   m_val [N][2];
   bit            e_iv;
   bit [OW-1:0]   e_opc;
   bit [TW-1:0]   e_dst;
   bit [VW-1:0]   e_lv, e_rv;

   function automatic bit [N-1:0] model_bid();
      bit [N-1:0] r = '0;
      for (int e = 0; e < N; e++)
         r[e] = m_v[e] && !m_iss[e] && m_rdy[e][0] && m_rdy[e][1];
      return r;
   endfunction

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_en = 0; alloc_idx = '0; alloc_opc = '0; alloc_dst = '0;
      for (int s = 0; s < 2; s++) begin a_tag[s] = '0; a_rdy[s] = 0; a_val[s] = '0; a_dly[s] = '0; end
      bc_valid = '0;
      for (int b = 0; b < B; b++) begin b_tag[b] = '0; b_val[b] = '0; end
      dealloc = '0; grant = '0;
   endtask

   // bus match per R3: lowest index wins
   task automatic bus_hit(input bit [TW-1:0] t, output bit h, output bit [VW-1:0] v);
      h = 0; v = '0;
      for (int b = B - 1; b >= 0; b--)
         if (bc_valid[b] && b_tag[b] == t) begin h = 1; v = b_val[b]; end
   endtask

   task automatic take_hit(input int e, input int s, input bit [DW-1:0] d, input bit [VW-1:0] v);
      m_val[e][s] = v;
      if (d == 0) begin m_rdy[e][s] = 1; m_pend[e][s] = 0; end
      else begin m_rdy[e][s] = 0; m_pend[e][s] = 1; m_cnt[e][s] = d; end
   endtask

   task automatic cycle();
      bit [N-1:0] mb, sel;
      bit h;
      bit [VW-1:0] hv;
      mb = model_bid();
      sel = grant & mb;
      e_iv = |sel;
      for (int e = 0; e < N; e++) if (sel[e]) begin
         e_opc = m_opc[e]; e_dst = m_dst[e]; e_lv = m_val[e][0]; e_rv = m_val[e][1];
      end
      for (int e = 0; e < N; e++) begin
         bit wr;
         wr = alloc_en && alloc_idx == IW'(e);
         for (int s = 0; s < 2; s++) begin
            if (wr) begin
               m_tag[e][s] = a_tag[s]; m_dly[e][s] = a_dly[s];
               if (a_rdy[s]) begin m_rdy[e][s] = 1; m_pend[e][s] = 0; m_val[e][s] = a_val[s]; end
               else begin
                  bus_hit(a_tag[s], h, hv);
                  if (h) take_hit(e, s, a_dly[s], hv);
                  else begin m_rdy[e][s] = 0; m_pend[e][s] = 0; end
               end
            end else if (m_v[e] && !m_rdy[e][s]) begin
               if (m_pend[e][s]) begin
                  if (m_cnt[e][s] == 1) begin m_rdy[e][s] = 1; m_pend[e][s] = 0; end
                  m_cnt[e][s] = m_cnt[e][s] - 1;
               end else begin
                  bus_hit(m_tag[e][s], h, hv);
                  if (h) take_hit(e, s, m_dly[e][s], hv);
               end
            end
         end
         if (wr) begin m_v[e] = 1; m_iss[e] = 0; m_opc[e] = alloc_opc; m_dst[e] = alloc_dst; end
         else begin
            if (dealloc[e]) m_v[e] = 0;
            if (sel[e]) m_iss[e] = 1;
         end
      end
      @(posedge clk);
      cycles++;
      @(negedge clk);
      check(bid === model_bid(), "bid vector (R2,R7,R8)", 64'(bid), 64'(model_bid()));
      check(iss_valid === e_iv, "iss_valid (R6,R9)", 64'(iss_valid), 64'(e_iv));
      if (e_iv && iss_valid) begin
         check(iss_opc === e_opc && iss_dst === e_dst, "issue opcode/dst (R6)",
               {iss_opc, iss_dst}, {e_opc, e_dst});
         check(iss_l_val === e_lv, "issue left value (R3,R10)", 64'(iss_l_val), 64'(e_lv));
         check(iss_r_val === e_rv, "issue right value (R3,R10)", 64'(iss_r_val), 64'(e_rv));
      end
      idle();
   endtask

   task automatic wr(input int e, input bit [TW-1:0] lt, input bit lr, input bit [VW-1:0] lv,
                     input bit [DW-1:0] ld, input bit [TW-1:0] rt, input bit rr, input bit [VW-1:0] rv);
      alloc_en = 1; alloc_idx = IW'(e); alloc_opc = OW'(8'h30 + e); alloc_dst = TW'(40 + e);
      a_tag[0] = lt; a_rdy[0] = lr; a_val[0] = lv; a_dly[0] = ld;
      a_tag[1] = rt; a_rdy[1] = rr; a_val[1] = rv; a_dly[1] = '0;
   endtask

   task automatic bcast(input int b, input bit [TW-1:0] t, input bit [VW-1:0] v);
      bc_valid[b] = 1; b_tag[b] = t; b_val[b] = v;
   endtask

   initial begin
      while (cycles < 150000) @(posedge clk);
      failures++;
      $display("FAIL %s watchdog expired actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      idle();
      for (int e = 0; e < N; e++) begin
         m_v[e] = 0; m_iss[e] = 0; m_opc[e] = '0; m_dst[e] = '0;
         for (int s = 0; s < 2; s++) begin
            m_rdy[e][s] = 0; m_pend[e][s] = 0; m_tag[e][s] = '0;
            m_dly[e][s] = '0; m_cnt[e][s] = '0; m_val[e][s] = '0;
         end
      end
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check(bid === '0, "bid in reset R1", 64'(bid), 64'(0));
      check(iss_valid === 1'b0, "iss_valid in reset R1", 64'(iss_valid), 64'(0));
      rst_n = 1;
      @(negedge clk);
      check(bid === '0 && iss_valid === 1'b0, "idle after reset R1", 64'({bid, iss_valid}), 64'(0));

      cur_req = "R2";
      wr(0, 6'd1, 1, 32'hAAAA0001, 0, 6'd2, 1, 32'hBBBB0001); cycle();
      check(bid[0] === 1'b1, "ready write bids R2", 64'(bid[0]), 64'(1));
      cur_req = "R6";
      grant = 8'h01; cycle();
      check(iss_l_val === 32'hAAAA0001 && iss_r_val === 32'hBBBB0001, "issued values R6",
            {iss_l_val, iss_r_val}, {32'hAAAA0001, 32'hBBBB0001});
      cur_req = "R7";
      check(bid[0] === 1'b0, "no rebid R7", 64'(bid[0]), 64'(0));
      cycle();

      cur_req = "R3";
      wr(1, 6'd5, 0, '0, 0, 6'd2, 1, 32'h11); cycle();
      check(bid[1] === 1'b0, "waiting source no bid R3", 64'(bid[1]), 64'(0));
      bcast(1, 6'd5, 32'hC0DE0005); cycle();
      check(bid[1] === 1'b1, "wakeup on bus1 R3", 64'(bid[1]), 64'(1));
      grant = 8'h02; cycle();
      check(iss_l_val === 32'hC0DE0005, "captured bus value R3", 64'(iss_l_val), 64'(32'hC0DE0005));
      wr(2, 6'd9, 0, '0, 0, 6'd2, 1, 32'h22); cycle();
      bcast(0, 6'd9, 32'h00000B00); bcast(1, 6'd9, 32'h00000B11); cycle();
      grant = 8'h04; cycle();
      check(iss_l_val === 32'h00000B00, "lowest bus wins R3", 64'(iss_l_val), 64'(32'h00000B00));

      cur_req = "R4";
      wr(3, 6'd12, 0, '0, 3, 6'd2, 1, 32'h33); cycle();
      bcast(0, 6'd12, 32'hD0D0); cycle();
      bcast(1, 6'd12, 32'hEEEE); cycle();
      check(bid[3] === 1'b0, "delay 3 not yet after edge E+1 R4", 64'(bid[3]), 64'(0));
      cycle();
      check(bid[3] === 1'b0, "delay 3 not yet after edge E+2 R4", 64'(bid[3]), 64'(0));
      cycle();
      check(bid[3] === 1'b1, "delay 3 ready after edge E+3 R4", 64'(bid[3]), 64'(1));
      grant = 8'h08; cycle();
      check(iss_l_val === 32'hD0D0, "value from matching edge R4", 64'(iss_l_val), 64'(32'hD0D0));

      cur_req = "R5";
      wr(4, 6'd20, 0, '0, 0, 6'd2, 1, 32'h44); bcast(0, 6'd20, 32'h5A5A); cycle();
      check(bid[4] === 1'b1, "same-cycle broadcast taken R5", 64'(bid[4]), 64'(1));
      wr(6, 6'd21, 0, '0, 1, 6'd2, 1, 32'h66); bcast(1, 6'd21, 32'h6B6B); cycle();
      check(bid[6] === 1'b0, "same-cycle with delay 1 waits R5", 64'(bid[6]), 64'(0));
      cycle();
      check(bid[6] === 1'b1, "same-cycle with delay 1 ready R5", 64'(bid[6]), 64'(1));

      cur_req = "R9";
      grant = 8'h20; cycle();
      check(iss_valid === 1'b0, "grant to free slot ignored R9", 64'(iss_valid), 64'(0));

      cur_req = "R10";
      bcast(0, 6'd20, 32'hBAD0); cycle();
      grant = 8'h10; cycle();
      check(iss_l_val === 32'h5A5A, "ready source keeps first value R10", 64'(iss_l_val), 64'(32'h5A5A));

      cur_req = "R8";
      dealloc = 8'h40; cycle();
      check(bid[6] === 1'b0, "released slot silent R8", 64'(bid[6]), 64'(0));
      wr(7, 6'd1, 1, 32'h7, 0, 6'd2, 1, 32'h7); dealloc = 8'h80; cycle();
      check(bid[7] === 1'b1, "write beats release R8", 64'(bid[7]), 64'(1));

      cur_req = "R3,R4,R5,R6,R7,R8,R10";
      for (int it = 0; it < 4000; it++) begin
         bit [N-1:0] mb;
         int pick;
         mb = model_bid();
         pick = int'($urandom % N);
         if (!m_v[pick] || m_iss[pick] || ($urandom % 16) == 0) begin
            if (($urandom % 2) == 0) begin
               alloc_en = 1; alloc_idx = IW'(pick); alloc_opc = OW'($urandom); alloc_dst = TW'($urandom);
               for (int s = 0; s < 2; s++) begin
                  a_tag[s] = TW'($urandom % 8); a_rdy[s] = (($urandom % 5) < 2);
                  a_val[s] = $urandom; a_dly[s] = DW'($urandom);
               end
            end
         end
         for (int b = 0; b < B; b++) begin
            bc_valid[b] = (($urandom % 3) != 0); b_tag[b] = TW'($urandom % 8); b_val[b] = $urandom;
         end
         if (($urandom % 10) < 7 && mb != '0) begin
            int g;
            g = int'($urandom % N);
            for (int k = 0; k < N; k++) begin
               if (mb[(g + k) % N] && grant == '0) grant[(g + k) % N] = 1'b1;
            end
         end else if (($urandom % 20) == 0) begin
            grant[$urandom % N] = 1'b1;
         end
         for (int e = 0; e < N; e++)
            if (m_v[e] && m_iss[e] && ($urandom % 4) == 0) dealloc[e] = 1'b1;
         if (($urandom % 50) == 0) dealloc[$urandom % N] = 1'b1;
         cycle();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule